// File: doc/BRIEF.md
# I2C Read-Only Status Register Target

This block is an I2C target that serves read transactions only. It monitors the SCL and SDA lines with the system clock, recognises start and stop conditions and compares the first byte after a start with its 7-bit address. The upper six address bits are fixed and the lowest bit comes from a strap pin. When the address matches and the direction bit asks for a read, the target acknowledges. It then streams a bank of eight 8-bit status values, presented as a parallel input, onto SDA.

Every transaction begins at the first status value and walks the bank in a fixed order. The walk ends when the master declines a byte or when all eight bytes have been sent. The bank is copied into a shadow store at the instant the address matches, so all bytes in one transaction come from the same snapshot. The SDA output is open-drain: the block only reports whether it pulls the line low. An enable input gates the whole interface.

Top module: `i2c_status_reader`

## Requirements
- R1: After reset, `sda_pull` is 0 (SDA released) and stays 0 until a matching address has been received.
- R2: When the byte after a start equals {6'b001000, `addr_pin`} in bits 7..1 with bit 0 (direction) = 1, the target pulls SDA low for the ninth clock (acknowledge).
- R3: If bits 7..1 differ from that address, or bit 0 is 0 (write), the target does not acknowledge and leaves SDA released until the next start.
- R4: Data bytes go out MSB first. Byte k of a transaction is `status_regs[8k+7:8k]`, and every transaction starts at k = 0.
- R5: The target changes its SDA output only while SCL is low.
- R6: When the master answers a data byte with a not-acknowledge (SDA high), the target releases SDA until the next start.
- R7: After the eighth byte the target releases SDA, even if the master acknowledges that byte.
- R8: A start or repeated start at any point aborts the current transfer and restarts address reception, with the byte pointer back at register 0.
- R9: `status_regs` is captured when the address matches. Changes to it later in the same transaction do not alter the bytes returned.
- R10: A stop condition returns the target to idle with SDA released.
- R11: While `bus_en` is 0 the target ignores the bus and never pulls SDA low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used to oversample SCL and SDA |
| rst | input | 1 | Synchronous active-high reset |
| bus_en | input | 1 | Interface enable; 0 keeps the target idle and released |
| addr_pin | input | 1 | Strap giving address bit 0 |
| scl_i | input | 1 | SCL line level |
| sda_i | input | 1 | SDA line level (wired-AND of all drivers) |
| status_regs | input | 64 | Eight status bytes; byte k in bits 8k+7..8k |
| sda_pull | output | 1 | 1 pulls SDA low, 0 releases it |

## Verification
Two decisions fall on the same SCL rising edge. The first is sampling the master's acknowledge after a byte. The second is the end-of-bank check that stops the walk after byte eight. The bench provokes this by acknowledging the eighth byte, then clocking nine more bits with SDA released and requiring them all to read 1. A second overlap is the shadow capture against a change of `status_regs` in the middle of a transaction. It is judged by comparing the returned bytes with the values present when the address was sent.

// File: rtl/i2c_status_pkg.sv
package i2c_status_pkg;
  localparam int NUM_REGS = 8;
  localparam int REG_W    = 8;
  localparam logic [5:0] ADDR_HIGH = 6'b001000;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADDR,
    ST_ACK_PEND,
    ST_ACK_DRV,
    ST_TX,
    ST_MACK,
    ST_LOAD
  } rd_state_t;
endpackage

// File: rtl/i2c_line_monitor.sv
module i2c_line_monitor #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_lvl,
  output logic sda_lvl,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_det,
  output logic stop_det
);
  localparam int PW = SYNC_STAGES + 1;

  logic [PW-1:0] scl_p;
  logic [PW-1:0] sda_p;
  logic scl_prev, sda_prev;

  always_ff @(posedge clk) begin
    if (rst) begin
      scl_p <= '1;
      sda_p <= '1;
    end else begin
      scl_p <= {scl_p[PW-2:0], scl_i};
      sda_p <= {sda_p[PW-2:0], sda_i};
    end
  end

  assign scl_lvl  = scl_p[SYNC_STAGES-1];
  assign sda_lvl  = sda_p[SYNC_STAGES-1];
  assign scl_prev = scl_p[SYNC_STAGES];
  assign sda_prev = sda_p[SYNC_STAGES];

  assign scl_rise  = scl_lvl & ~scl_prev;
  assign scl_fall  = ~scl_lvl & scl_prev;
  assign start_det = scl_lvl & scl_prev & sda_prev & ~sda_lvl;
  assign stop_det  = scl_lvl & scl_prev & ~sda_prev & sda_lvl;
endmodule

// File: rtl/i2c_shadow_bank.sv
module i2c_shadow_bank #(
  parameter int NUM_REGS = 8,
  parameter int REG_W    = 8,
  localparam int IW      = $clog2(NUM_REGS)
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      load,
  input  logic [NUM_REGS*REG_W-1:0] regs_in,
  input  logic [IW-1:0]             sel,
  output logic [REG_W-1:0]          sel_byte
);
  logic [NUM_REGS-1:0][REG_W-1:0] shadow_q;

  for (genvar g = 0; g < NUM_REGS; g++) begin : g_reg
    always_ff @(posedge clk) begin
      if (rst)
        shadow_q[g] <= '0;
      else if (load)
        shadow_q[g] <= regs_in[g*REG_W +: REG_W];
    end
  end

  assign sel_byte = shadow_q[sel];

  // R9
  shadow_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !load |=> $stable(shadow_q));
endmodule

// File: rtl/i2c_read_fsm.sv
module i2c_read_fsm
  import i2c_status_pkg::*;
#(
  parameter int NUM_REGS = 8,
  parameter int REG_W    = 8,
  localparam int IW      = $clog2(NUM_REGS),
  localparam int CW      = $clog2(REG_W)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             bus_en,
  input  logic             addr_pin,
  input  logic             scl_lvl,
  input  logic             sda_lvl,
  input  logic             scl_rise,
  input  logic             scl_fall,
  input  logic             start_det,
  input  logic             stop_det,
  input  logic [REG_W-1:0] cur_byte,
  output logic [IW-1:0]    byte_idx,
  output logic             shadow_load,
  output logic             sda_oe
);
  localparam logic [CW-1:0] LAST_BIT = CW'(REG_W - 1);
  localparam logic [CW-1:0] NEXT_TOP = CW'(REG_W - 2);
  localparam logic [IW-1:0] LAST_IDX = IW'(NUM_REGS - 1);

  rd_state_t       state;
  logic [CW-1:0]   bit_cnt;
  logic [REG_W-2:0] shift_q;
  logic [REG_W-1:0] addr_byte;
  logic            addr_hit;
  logic [CW-1:0]   bit_sel;

  assign addr_byte = {shift_q, sda_lvl};
  assign addr_hit  = (addr_byte[7:1] == {ADDR_HIGH, addr_pin}) && addr_byte[0];
  assign bit_sel   = NEXT_TOP - bit_cnt;

  assign shadow_load = bus_en && !start_det && !stop_det && (state == ST_ADDR)
                       && scl_rise && (bit_cnt == LAST_BIT) && addr_hit;

  always_ff @(posedge clk) begin
    if (rst || !bus_en) begin
      state    <= ST_IDLE;
      bit_cnt  <= '0;
      byte_idx <= '0;
      shift_q  <= '0;
      sda_oe   <= 1'b0;
    end else if (start_det) begin
      state    <= ST_ADDR;
      bit_cnt  <= '0;
      byte_idx <= '0;
      sda_oe   <= 1'b0;
    end else if (stop_det) begin
      state  <= ST_IDLE;
      sda_oe <= 1'b0;
    end else begin
      case (state)
        ST_ADDR: if (scl_rise) begin
          shift_q <= addr_byte[REG_W-2:0];
          bit_cnt <= bit_cnt + 1'b1;
          if (bit_cnt == LAST_BIT)
            state <= addr_hit ? ST_ACK_PEND : ST_IDLE;
        end
        ST_ACK_PEND: if (scl_fall) begin
          sda_oe <= 1'b1;
          state  <= ST_ACK_DRV;
        end
        ST_ACK_DRV, ST_LOAD: if (scl_fall) begin
          sda_oe  <= ~cur_byte[REG_W-1];
          bit_cnt <= '0;
          state   <= ST_TX;
        end
        ST_TX: if (scl_fall) begin
          if (bit_cnt == LAST_BIT) begin
            sda_oe <= 1'b0;
            state  <= ST_MACK;
          end else begin
            sda_oe  <= ~cur_byte[bit_sel];
            bit_cnt <= bit_cnt + 1'b1;
          end
        end
        ST_MACK: if (scl_rise) begin
          if (!sda_lvl && byte_idx != LAST_IDX) begin
            byte_idx <= byte_idx + 1'b1;
            state    <= ST_LOAD;
          end else begin
            state <= ST_IDLE;
          end
        end
        default: sda_oe <= 1'b0;
      endcase
    end
  end

  // R5
  sda_oe_stable_chk: assert property (@(posedge clk) disable iff (rst)
    (bus_en && $past(bus_en) && scl_lvl && $past(scl_lvl)) |-> $stable(sda_oe));

  // R11
  disabled_release_chk: assert property (@(posedge clk) disable iff (rst)
    !bus_en |=> !sda_oe);

  // R8
  start_restart_chk: assert property (@(posedge clk) disable iff (rst)
    (bus_en && start_det) |=> (state == ST_ADDR && byte_idx == '0));

  // R6
  mack_slot_free_chk: assert property (@(posedge clk) disable iff (rst)
    (state == ST_MACK) |-> !sda_oe);

  // R10
  idle_released_chk: assert property (@(posedge clk) disable iff (rst)
    (state == ST_IDLE) |-> !sda_oe);
endmodule

// File: rtl/i2c_status_reader.sv
module i2c_status_reader
  import i2c_status_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      bus_en,
  input  logic                      addr_pin,
  input  logic                      scl_i,
  input  logic                      sda_i,
  input  logic [NUM_REGS*REG_W-1:0] status_regs,
  output logic                      sda_pull
);
  localparam int IW = $clog2(NUM_REGS);

  logic scl_lvl, sda_lvl, scl_rise, scl_fall, start_det, stop_det;
  logic shadow_load;
  logic [IW-1:0] byte_idx;
  logic [REG_W-1:0] cur_byte;

  i2c_line_monitor #(.SYNC_STAGES(SYNC_STAGES)) u_mon (
    .clk(clk), .rst(rst), .scl_i(scl_i), .sda_i(sda_i),
    .scl_lvl(scl_lvl), .sda_lvl(sda_lvl),
    .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_det(start_det), .stop_det(stop_det)
  );

  i2c_shadow_bank #(.NUM_REGS(NUM_REGS), .REG_W(REG_W)) u_bank (
    .clk(clk), .rst(rst), .load(shadow_load), .regs_in(status_regs),
    .sel(byte_idx), .sel_byte(cur_byte)
  );

  i2c_read_fsm #(.NUM_REGS(NUM_REGS), .REG_W(REG_W)) u_fsm (
    .clk(clk), .rst(rst), .bus_en(bus_en), .addr_pin(addr_pin),
    .scl_lvl(scl_lvl), .sda_lvl(sda_lvl),
    .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_det(start_det), .stop_det(stop_det),
    .cur_byte(cur_byte), .byte_idx(byte_idx),
    .shadow_load(shadow_load), .sda_oe(sda_pull)
  );
endmodule

// File: tb/i2c_status_reader_test.sv
module i2c_status_reader_test;
  localparam int HALF = 10;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic bus_en = 1'b1;
  logic addr_pin = 1'b0;
  logic scl_m = 1'b1;
  logic sda_m = 1'b1;
  logic [63:0] regs = '0;
  logic sda_pull;
  wire  sda_line = sda_m & ~sda_pull;

  int total = 0;
  int fails = 0;
  bit done = 0;

  always #5 clk = ~clk;

  i2c_status_reader uut (
    .clk(clk), .rst(rst), .bus_en(bus_en), .addr_pin(addr_pin),
    .scl_i(scl_m), .sda_i(sda_line), .status_regs(regs), .sda_pull(sda_pull)
  );

  function automatic logic [7:0] exp_byte(logic [63:0] r, int k);
    return r[8*k +: 8];
  endfunction

  task automatic chk(bit ok, string tag, logic [7:0] act, logic [7:0] exp);
    total++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wait_clk(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic do_start();
    sda_m = 1'b1; wait_clk(HALF);
    scl_m = 1'b1; wait_clk(HALF);
    sda_m = 1'b0; wait_clk(HALF);
    scl_m = 1'b0; wait_clk(HALF);
  endtask

  task automatic do_stop();
    sda_m = 1'b0; wait_clk(HALF);
    scl_m = 1'b1; wait_clk(HALF);
    sda_m = 1'b1; wait_clk(HALF);
  endtask

  task automatic put_bit(logic b);
    sda_m = b;    wait_clk(HALF);
    scl_m = 1'b1; wait_clk(HALF);
    scl_m = 1'b0; wait_clk(2);
  endtask

  task automatic get_bit(output logic b);
    sda_m = 1'b1; wait_clk(HALF);
    scl_m = 1'b1; wait_clk(HALF / 2);
    b = sda_line; wait_clk(HALF / 2);
    scl_m = 1'b0; wait_clk(2);
  endtask

  task automatic put_byte(logic [7:0] v);
    for (int i = 7; i >= 0; i--) put_bit(v[i]);
  endtask

  task automatic get_byte(output logic [7:0] v);
    logic b;
    for (int i = 7; i >= 0; i--) begin
      get_bit(b);
      v[i] = b;
    end
  endtask

  // start, address byte, acknowledge sample
  task automatic send_addr(logic [6:0] a, logic rw, output logic ack);
    do_start();
    put_byte({a, rw});
    get_bit(ack);
  endtask

  // full read of n bytes with checks, master NACKs the last one
  task automatic read_txn(int n, string tag);
    logic ack;
    logic [7:0] v;
    logic [63:0] snap;
    snap = regs;
    send_addr({6'b001000, addr_pin}, 1'b1, ack);
    chk(ack == 1'b0, "R2 address ack", {7'd0, ack}, 8'd0);
    for (int k = 0; k < n; k++) begin
      get_byte(v);
      chk(v == exp_byte(snap, k), tag, v, exp_byte(snap, k));
      put_bit(k == n - 1);
    end
    do_stop();
  endtask

  // clocks nine bits with SDA released and checks that all read 1
  task automatic expect_released(string tag);
    logic [7:0] v;
    logic b;
    get_byte(v);
    get_bit(b);
    chk(v == 8'hFF && b == 1'b1, tag, v, 8'hFF);
  endtask

  initial begin
    logic ack;
    logic [7:0] v;
    logic [63:0] snap;
    void'($urandom(32'd20240611));
    wait_clk(5);
    rst = 1'b0;
    wait_clk(3);
    // R1
    chk(sda_pull == 1'b0, "R1 reset release", {7'd0, sda_pull}, 8'd0);

    regs = 64'h8877_6655_4433_2211;
    // R4 one-byte and five-byte reads
    read_txn(1, "R4 one byte");
    read_txn(5, "R4 five bytes");
    addr_pin = 1'b1;
    read_txn(3, "R2 R4 strap high");

    // R3 wrong LSB of address
    send_addr(7'b0010000, 1'b1, ack);
    chk(ack == 1'b1, "R3 wrong address no ack", {7'd0, ack}, 8'd1);
    expect_released("R3 released after mismatch");
    do_stop();

    // R3 write direction
    send_addr(7'b0010001, 1'b0, ack);
    chk(ack == 1'b1, "R3 write no ack", {7'd0, ack}, 8'd1);
    expect_released("R3 released after write");
    do_stop();

    // R7 all eight acked by master, then released
    regs = 64'h0123_4567_89AB_CDEF;
    snap = regs;
    send_addr(7'b0010001, 1'b1, ack);
    chk(ack == 1'b0, "R2 ack before full walk", {7'd0, ack}, 8'd0);
    for (int k = 0; k < 8; k++) begin
      get_byte(v);
      chk(v == exp_byte(snap, k), "R4 R7 full walk", v, exp_byte(snap, k));
      put_bit(1'b0);
    end
    expect_released("R7 released after eighth byte");
    do_stop();

    // R6 NACK then extra clocks, then R8 repeated start restarts at 0
    send_addr(7'b0010001, 1'b1, ack);
    get_byte(v);
    chk(v == exp_byte(snap, 0), "R4 byte0", v, exp_byte(snap, 0));
    put_bit(1'b0);
    get_byte(v);
    chk(v == exp_byte(snap, 1), "R4 byte1", v, exp_byte(snap, 1));
    put_bit(1'b1);
    expect_released("R6 released after nack");
    send_addr(7'b0010001, 1'b1, ack);
    chk(ack == 1'b0, "R8 repeated start ack", {7'd0, ack}, 8'd0);
    get_byte(v);
    chk(v == exp_byte(snap, 0), "R8 restart at register 0", v, exp_byte(snap, 0));
    put_bit(1'b1);
    do_stop();

    // R8 start in middle of address byte
    do_start();
    put_bit(1'b0); put_bit(1'b0); put_bit(1'b1); put_bit(1'b1);
    read_txn(2, "R8 abort mid address");

    // R9 input change mid transaction
    regs = 64'hA5A5_5A5A_F00F_0FF0;
    snap = regs;
    send_addr(7'b0010001, 1'b1, ack);
    regs = ~regs;
    for (int k = 0; k < 4; k++) begin
      get_byte(v);
      chk(v == exp_byte(snap, k), "R9 shadow coherence", v, exp_byte(snap, k));
      put_bit(k == 3);
    end
    do_stop();
    // R10 after stop, line released
    wait_clk(HALF);
    chk(sda_pull == 1'b0, "R10 idle after stop", {7'd0, sda_pull}, 8'd0);

    // R11 disabled interface
    bus_en = 1'b0;
    send_addr(7'b0010001, 1'b1, ack);
    chk(ack == 1'b1, "R11 disabled no ack", {7'd0, ack}, 8'd1);
    expect_released("R11 disabled released");
    do_stop();
    bus_en = 1'b1;
    wait_clk(HALF);

    // random reads
    for (int t = 0; t < 30; t++) begin
      regs = {$urandom, $urandom};
      addr_pin = 1'($urandom % 2);
      read_txn(1 + int'($urandom % 8), "R4 random read");
    end

    done = 1;
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      total++;
      fails++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end
endmodule